// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block turns a single request into one complete processor machine cycle on a classic 8-bit bus. The supported cycles are:

- opcode fetch, which ends with a refresh phase;
- memory read;
- memory write;
- port read and port write;
- maskable interrupt acknowledge.

For each cycle the block drives the active-low control strobes and the address bus, drives write data, and captures read data. A single-clock pulse reports the end of the cycle. Time advances in T-states. One T-state lasts from one clock-enable tick (`ce` high at a rising clock edge) to the next, so the enclosing core can run the bus at any fraction of the fabric clock.

A request is presented as a cycle kind with the following fields:

- the address or port number;
- the refresh address;
- the write data.

A request is taken only on a tick while the sequencer is idle. Every field is latched when the request is taken. Port and acknowledge cycles contain built-in wait states, set by parameters with defaults of one and two. The `wait_n` input can stretch the data phase further, one T-state per tick on which it is sampled low. All outputs come from registers, and they change only on ticks.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset and while idle, all six strobes (`mreq_n`, `rd_n`, `wr_n`, `m1_n`, `iorq_n`, `rfsh_n`) are high. `done` and `dbus_oe` are low, and `addr_o` is zero after reset.
- R2: A request is accepted only on a tick with `req` high while idle and `req_kind` in the range 0..5. The kind codes are 0 fetch, 1 memory read, 2 memory write, 3 port read, 4 port write and 5 interrupt acknowledge. Codes 6 and 7, or a request on a clock without `ce`, start no cycle.
- R3: Fetch lasts 4+W T-states, where W is the number of inserted waits. For the first 2+W T-states, `m1_n`, `mreq_n` and `rd_n` are low and `addr_o` carries the request address. For the last two T-states, `mreq_n` and `rfsh_n` are low and `addr_o` carries the refresh address.
- R4: Memory read lasts 3+W T-states, with `mreq_n` and `rd_n` low in all of them.
- R5: Memory write lasts 3+W T-states. `mreq_n` is low throughout, while `wr_n` is low from the second T-state to the end. `dbus_oe` is high exactly while `wr_n` is low, and `dbus_out` then carries the latched write data. `rd_n` and `wr_n` are never low together.
- R6: Port read or write lasts 4+W T-states, one of them a built-in wait. `iorq_n` together with `rd_n` (for reads) or `wr_n` (for writes) is low from the second T-state to the end, and `mreq_n` stays high.
- R7: Interrupt acknowledge lasts 6+W T-states. `m1_n` is low for the first 4+W T-states, and `iorq_n` is low from the third of those to the last of them. The last two T-states are a refresh phase with `mreq_n` and `rfsh_n` low and the refresh address on `addr_o`.
- R8: `wait_n` is sampled on the tick that ends the last fixed data-phase T-state, and on each tick that ends an inserted wait. Every low sample adds one T-state to the data phase. The T-states sampled are the second for fetch and memory cycles, the third for port cycles and the fourth for acknowledge.
- R9: For fetch, memory read, port read and acknowledge, `rdata` takes the value of `rd_data` on the tick that ends the last data-phase T-state. Write cycles leave `rdata` unchanged.
- R10: `done` is high for exactly one clock, right after the tick that ends the final T-state. At that same point every strobe is high again.
- R11: Strobes, `addr_o` and `dbus_oe` hold their values on clocks without `ce`.
- R12: During a cycle, changes to `req`, `req_kind`, `req_addr`, `req_rfsh` and `req_wdata` have no effect on the strobes, the address or the driven data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | T-state tick enable |
| req | input | 1 | Request a machine cycle |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | ADDR_W | Memory address or port number |
| req_rfsh | input | ADDR_W | Refresh address for the refresh phase |
| req_wdata | input | DATA_W | Data for write cycles |
| wait_n | input | 1 | Active-low wait request |
| rd_data | input | DATA_W | Incoming data bus |
| addr_o | output | ADDR_W | Address bus |
| dbus_out | output | DATA_W | Outgoing data bus |
| dbus_oe | output | 1 | Outgoing data bus enable |
| mreq_n | output | 1 | Memory request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| m1_n | output | 1 | Fetch / acknowledge marker |
| iorq_n | output | 1 | Port request strobe |
| rfsh_n | output | 1 | Refresh strobe |
| rdata | output | DATA_W | Captured read data |
| done | output | 1 | End-of-cycle pulse |

## Verification
The hardest situation to reach is a wait request landing on the exact T-state where sampling happens, after the built-in waits of a port or acknowledge cycle. It is made harder when the ticks are spaced irregularly and the request inputs change mid-cycle. To reach it, the stimulus holds `wait_n` low only for a chosen number of ticks starting at the sampling T-state of that kind. It inserts random idle clocks between ticks and scrambles the request inputs on every tick of a cycle, so off-by-one sampling, lost latching and strobe changes on non-tick clocks all show up in the expected per-T-state strobe pattern.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int KIND_W = 3;

  localparam logic [KIND_W-1:0] K_FETCH = 3'd0;
  localparam logic [KIND_W-1:0] K_MRD   = 3'd1;
  localparam logic [KIND_W-1:0] K_MWR   = 3'd2;
  localparam logic [KIND_W-1:0] K_IORD  = 3'd3;
  localparam logic [KIND_W-1:0] K_IOWR  = 3'd4;
  localparam logic [KIND_W-1:0] K_IACK  = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_TA,
    ST_TW,
    ST_T3,
    ST_T4
  } tstate_e;

  typedef struct packed {
    logic mreq_n;
    logic rd_n;
    logic wr_n;
    logic m1_n;
    logic iorq_n;
    logic rfsh_n;
  } strobe_t;

  localparam strobe_t STROBES_OFF = strobe_t'(6'h3F);

  function automatic logic kind_ok(input logic [KIND_W-1:0] k);
    return k <= K_IACK;
  endfunction

  function automatic logic kind_io(input logic [KIND_W-1:0] k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction

  function automatic logic kind_rfsh(input logic [KIND_W-1:0] k);
    return (k == K_FETCH) || (k == K_IACK);
  endfunction

  function automatic logic kind_auto(input logic [KIND_W-1:0] k);
    return kind_io(k) || (k == K_IACK);
  endfunction

endpackage

// File: rtl/bcs_tstate_fsm.sv
module bcs_tstate_fsm
  import bcs_pkg::*;
#(
  parameter int unsigned IO_AUTO_WAITS  = 1,
  parameter int unsigned ACK_AUTO_WAITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              req,
  input  logic [KIND_W-1:0] req_kind,
  input  logic              wait_n,
  output tstate_e           nxt_state,
  output logic [KIND_W-1:0] nxt_kind,
  output logic              accept,
  output logic              cap_en,
  output logic              fin
);

  localparam int unsigned MAX_AUTO = (IO_AUTO_WAITS > ACK_AUTO_WAITS) ? IO_AUTO_WAITS : ACK_AUTO_WAITS;
  localparam int CW = $clog2(MAX_AUTO + 1) + 1;
  localparam logic [CW-1:0] IO_LOAD  = CW'(IO_AUTO_WAITS - 1);
  localparam logic [CW-1:0] ACK_LOAD = CW'(ACK_AUTO_WAITS - 1);

  tstate_e           state_q;
  logic [KIND_W-1:0] kind_q;
  logic [CW-1:0]     cnt_q, nxt_cnt;

  // leaving the data phase toward T3 (wait released)
  function automatic logic cap_on_rfsh_entry(input logic [KIND_W-1:0] k);
    return kind_rfsh(k);
  endfunction

  always_comb begin
    nxt_state = state_q;
    nxt_kind  = kind_q;
    nxt_cnt   = cnt_q;
    accept    = 1'b0;
    cap_en    = 1'b0;
    fin       = 1'b0;
    if (ce) begin
      case (state_q)
        ST_IDLE: begin
          if (req && kind_ok(req_kind)) begin
            accept    = 1'b1;
            nxt_kind  = req_kind;
            nxt_state = ST_T1;
          end
        end
        ST_T1: nxt_state = ST_T2;
        ST_T2: begin
          if (kind_auto(kind_q)) begin
            nxt_state = ST_TA;
            nxt_cnt   = (kind_q == K_IACK) ? ACK_LOAD : IO_LOAD;
          end else if (!wait_n) begin
            nxt_state = ST_TW;
          end else begin
            nxt_state = ST_T3;
            cap_en    = cap_on_rfsh_entry(kind_q);
          end
        end
        ST_TA: begin
          if (cnt_q != '0) begin
            nxt_cnt = cnt_q - 1'b1;
          end else if (!wait_n) begin
            nxt_state = ST_TW;
          end else begin
            nxt_state = ST_T3;
            cap_en    = cap_on_rfsh_entry(kind_q);
          end
        end
        ST_TW: begin
          if (wait_n) begin
            nxt_state = ST_T3;
            cap_en    = cap_on_rfsh_entry(kind_q);
          end
        end
        ST_T3: begin
          if (kind_rfsh(kind_q)) begin
            nxt_state = ST_T4;
          end else begin
            nxt_state = ST_IDLE;
            fin       = 1'b1;
            cap_en    = (kind_q == K_MRD) || (kind_q == K_IORD);
          end
        end
        ST_T4: begin
          nxt_state = ST_IDLE;
          fin       = 1'b1;
        end
        default: nxt_state = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      kind_q  <= K_FETCH;
      cnt_q   <= '0;
    end else begin
      state_q <= nxt_state;
      kind_q  <= nxt_kind;
      cnt_q   <= nxt_cnt;
    end
  end

endmodule

// File: rtl/bcs_strobe_reg.sv
module bcs_strobe_reg
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  tstate_e           nxt_state,
  input  logic [KIND_W-1:0] nxt_kind,
  input  logic              fin,
  output strobe_t           strb_q,
  output logic              oe_q,
  output logic              done_q
);

  strobe_t strb_d;
  logic    in_fetch_data, in_rfsh, in_mem_all, in_after_t1, in_ack_data;

  always_comb begin
    in_fetch_data = nxt_state inside {ST_T1, ST_T2, ST_TW};
    in_rfsh       = nxt_state inside {ST_T3, ST_T4};
    in_mem_all    = nxt_state inside {ST_T1, ST_T2, ST_TW, ST_T3};
    in_after_t1   = nxt_state inside {ST_T2, ST_TA, ST_TW, ST_T3};
    in_ack_data   = nxt_state inside {ST_T1, ST_T2, ST_TA, ST_TW};

    strb_d = STROBES_OFF;
    case (nxt_kind)
      K_FETCH: begin
        if (in_fetch_data) begin
          strb_d.mreq_n = 1'b0;
          strb_d.rd_n   = 1'b0;
          strb_d.m1_n   = 1'b0;
        end else if (in_rfsh) begin
          strb_d.mreq_n = 1'b0;
          strb_d.rfsh_n = 1'b0;
        end
      end
      K_MRD: begin
        if (in_mem_all) begin
          strb_d.mreq_n = 1'b0;
          strb_d.rd_n   = 1'b0;
        end
      end
      K_MWR: begin
        if (in_mem_all) strb_d.mreq_n = 1'b0;
        if (in_mem_all && nxt_state != ST_T1) strb_d.wr_n = 1'b0;
      end
      K_IORD: begin
        if (in_after_t1) begin
          strb_d.iorq_n = 1'b0;
          strb_d.rd_n   = 1'b0;
        end
      end
      K_IOWR: begin
        if (in_after_t1) begin
          strb_d.iorq_n = 1'b0;
          strb_d.wr_n   = 1'b0;
        end
      end
      K_IACK: begin
        if (in_ack_data) strb_d.m1_n = 1'b0;
        if (nxt_state inside {ST_TA, ST_TW}) strb_d.iorq_n = 1'b0;
        if (in_rfsh) begin
          strb_d.mreq_n = 1'b0;
          strb_d.rfsh_n = 1'b0;
        end
      end
      default: strb_d = STROBES_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q <= STROBES_OFF;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (ce) begin
        strb_q <= strb_d;
        oe_q   <= ~strb_d.wr_n;
      end
    end
  end

endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              accept,
  input  logic              cap_en,
  input  tstate_e           nxt_state,
  input  logic [KIND_W-1:0] nxt_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_rfsh,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic [ADDR_W-1:0] adr_lat, rfa_lat, nxt_adr, nxt_rfa;
  logic              rfsh_phase;

  always_comb begin
    nxt_adr    = accept ? req_addr : adr_lat;
    nxt_rfa    = accept ? req_rfsh : rfa_lat;
    rfsh_phase = kind_rfsh(nxt_kind) && (nxt_state inside {ST_T3, ST_T4});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adr_lat <= '0;
      rfa_lat <= '0;
      wdata_q <= '0;
      addr_q  <= '0;
      rdata_q <= '0;
    end else if (ce) begin
      if (accept) begin
        adr_lat <= req_addr;
        rfa_lat <= req_rfsh;
        wdata_q <= req_wdata;
      end
      addr_q <= rfsh_phase ? nxt_rfa : nxt_adr;
      if (cap_en) rdata_q <= rd_data;
    end
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int IO_AUTO_WAITS  = 1,
  parameter int ACK_AUTO_WAITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              req,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_rfsh,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              wait_n,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dbus_out,
  output logic              dbus_oe,
  output logic              mreq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m1_n,
  output logic              iorq_n,
  output logic              rfsh_n,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  tstate_e           nxt_state;
  logic [KIND_W-1:0] nxt_kind;
  logic              accept, cap_en, fin;
  strobe_t           strb;

  bcs_tstate_fsm #(
    .IO_AUTO_WAITS (IO_AUTO_WAITS),
    .ACK_AUTO_WAITS(ACK_AUTO_WAITS)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .req      (req),
    .req_kind (req_kind),
    .wait_n   (wait_n),
    .nxt_state(nxt_state),
    .nxt_kind (nxt_kind),
    .accept   (accept),
    .cap_en   (cap_en),
    .fin      (fin)
  );

  bcs_strobe_reg u_strb (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .nxt_state(nxt_state),
    .nxt_kind (nxt_kind),
    .fin      (fin),
    .strb_q   (strb),
    .oe_q     (dbus_oe),
    .done_q   (done)
  );

  bcs_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .accept   (accept),
    .cap_en   (cap_en),
    .nxt_state(nxt_state),
    .nxt_kind (nxt_kind),
    .req_addr (req_addr),
    .req_rfsh (req_rfsh),
    .req_wdata(req_wdata),
    .rd_data  (rd_data),
    .addr_q   (addr_o),
    .wdata_q  (dbus_out),
    .rdata_q  (rdata)
  );

  assign mreq_n = strb.mreq_n;
  assign rd_n   = strb.rd_n;
  assign wr_n   = strb.wr_n;
  assign m1_n   = strb.m1_n;
  assign iorq_n = strb.iorq_n;
  assign rfsh_n = strb.rfsh_n;

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ce,
  input logic [ADDR_W-1:0] addr_o,
  input logic              dbus_oe,
  input logic              mreq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              m1_n,
  input logic              iorq_n,
  input logic              rfsh_n,
  input logic              done
);

  p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  p_oe_with_wr_r5: assert property (@(posedge clk) disable iff (rst)
    dbus_oe |-> !wr_n);

  p_iorq_no_mreq_r6: assert property (@(posedge clk) disable iff (rst)
    !iorq_n |-> mreq_n);

  p_rfsh_phase_r3: assert property (@(posedge clk) disable iff (rst)
    !rfsh_n |-> (!mreq_n && m1_n && rd_n && iorq_n));

  p_done_released_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (mreq_n && rd_n && wr_n && m1_n && iorq_n && rfsh_n && !dbus_oe));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable({mreq_n, rd_n, wr_n, m1_n, iorq_n, rfsh_n, dbus_oe, addr_o}));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ce     (ce),
  .addr_o (addr_o),
  .dbus_oe(dbus_oe),
  .mreq_n (mreq_n),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .m1_n   (m1_n),
  .iorq_n (iorq_n),
  .rfsh_n (rfsh_n),
  .done   (done)
);

// File: tb/bus_cycle_seq_test.sv
`timescale 1ns/1ps
module bus_cycle_seq_test;

  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst, ce, req, wait_n;
  logic [2:0]    req_kind;
  logic [AW-1:0] req_addr, req_rfsh;
  logic [DW-1:0] req_wdata, rd_data;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] dbus_out, rdata;
  logic          dbus_oe, mreq_n, rd_n, wr_n, m1_n, iorq_n, rfsh_n, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [DW-1:0] last_rdata = '0;

  always #2.5 clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst(rst), .ce(ce), .req(req), .req_kind(req_kind),
    .req_addr(req_addr), .req_rfsh(req_rfsh), .req_wdata(req_wdata),
    .wait_n(wait_n), .rd_data(rd_data), .addr_o(addr_o), .dbus_out(dbus_out),
    .dbus_oe(dbus_oe), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
    .iorq_n(iorq_n), .rfsh_n(rfsh_n), .rdata(rdata), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] strobes_now();
    return {mreq_n, rd_n, wr_n, m1_n, iorq_n, rfsh_n};
  endfunction

  function automatic int base_len(input logic [2:0] kd);
    case (kd)
      3'd0: return 4;
      3'd1, 3'd2: return 3;
      3'd3, 3'd4: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int sample_idx(input logic [2:0] kd);
    case (kd)
      3'd0, 3'd1, 3'd2: return 1;
      3'd3, 3'd4: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int cap_idx(input logic [2:0] kd, input int nw);
    case (kd)
      3'd0: return 1 + nw;
      3'd1: return 2 + nw;
      3'd3, 3'd5: return 3 + nw;
      default: return -1;
    endcase
  endfunction

  // {mreq_n, rd_n, wr_n, m1_n, iorq_n, rfsh_n, use_refresh_address}
  function automatic logic [6:0] exp_sig(input logic [2:0] kd, input int k, input int nw);
    logic mq, rd, wr, m1, io, rf, ua;
    {mq, rd, wr, m1, io, rf, ua} = 7'b0;
    case (kd)
      3'd0: if (k < 2 + nw) {mq, rd, m1} = 3'b111; else {mq, rf, ua} = 3'b111;
      3'd1: {mq, rd} = 2'b11;
      3'd2: begin mq = 1'b1; wr = (k >= 1); end
      3'd3: if (k >= 1) {io, rd} = 2'b11;
      3'd4: if (k >= 1) {io, wr} = 2'b11;
      default: if (k < 4 + nw) begin m1 = 1'b1; io = (k >= 2); end
               else {mq, rf, ua} = 3'b111;
    endcase
    return {~mq, ~rd, ~wr, ~m1, ~io, ~rf, ua};
  endfunction

  function automatic string kind_tag(input logic [2:0] kd);
    case (kd)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic tick();
    ce = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ce = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    check(strobes_now() == 6'h3F, tag, {58'd0, strobes_now()}, 64'h3F);
    check(done == 1'b0 && dbus_oe == 1'b0, tag, {62'd0, done, dbus_oe}, 64'd0);
  endtask

  task automatic check_tstate(input logic [2:0] kd, input int k, input int nw,
                              input logic [AW-1:0] a, input logic [AW-1:0] ra,
                              input logic [DW-1:0] wd, input string tag);
    logic [6:0]    e;
    logic [AW-1:0] ea;
    e  = exp_sig(kd, k, nw);
    ea = e[0] ? ra : a;
    check(strobes_now() == e[6:1], tag, {58'd0, strobes_now()}, {58'd0, e[6:1]});
    check(addr_o == ea, tag, {48'd0, addr_o}, {48'd0, ea});
    check(dbus_oe == ~e[4], tag, {63'd0, dbus_oe}, {63'd0, ~e[4]});
    if (dbus_oe) check(dbus_out == wd, tag, {56'd0, dbus_out}, {56'd0, wd});
  endtask

  task automatic run_cycle(input logic [2:0] kd, input int nw, input int gapmax, input bit noise);
    logic [AW-1:0] a, ra;
    logic [DW-1:0] wd, capv, dv;
    int total, s, ci, gaps;
    string tag;
    a  = AW'($urandom);
    ra = AW'($urandom);
    wd = DW'($urandom);
    capv = last_rdata;
    tag = noise ? "R12" : (nw > 0 ? "R8" : kind_tag(kd));
    req = 1'b1; req_kind = kd; req_addr = a; req_rfsh = ra; req_wdata = wd; wait_n = 1'b1;
    tick();
    req = 1'b0;
    total = base_len(kd) + nw;
    s  = sample_idx(kd);
    ci = cap_idx(kd, nw);
    for (int k = 0; k < total; k++) begin
      gaps = $urandom_range(0, gapmax);
      check_tstate(kd, k, nw, a, ra, wd, tag);
      for (int g = 0; g < gaps; g++) begin
        @(posedge clk);
        @(negedge clk);
        check_tstate(kd, k, nw, a, ra, wd, "R11");
      end
      wait_n = (k >= s && k < s + nw) ? 1'b0 : 1'b1;
      dv = DW'($urandom);
      rd_data = dv;
      if (k == ci) capv = dv;
      if (noise) begin
        req = 1'b1; req_kind = 3'($urandom); req_addr = AW'($urandom);
        req_rfsh = AW'($urandom); req_wdata = DW'($urandom);
      end
      tick();
      req = 1'b0; wait_n = 1'b1;
    end
    check(done == 1'b1, "R10", {63'd0, done}, 64'd1);
    check(strobes_now() == 6'h3F, "R10", {58'd0, strobes_now()}, 64'h3F);
    check(rdata == capv, "R9", {56'd0, rdata}, {56'd0, capv});
    last_rdata = capv;
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R10", {63'd0, done}, 64'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'h00C0FFEE);
    rst = 1'b1; ce = 1'b0; req = 1'b0; req_kind = '0; req_addr = '0; req_rfsh = '0;
    req_wdata = '0; wait_n = 1'b1; rd_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_idle("R1");
    check(addr_o == '0 && rdata == '0, "R1", {32'd0, addr_o, 8'd0, rdata}, 64'd0);

    // R2 unused codes and missing tick start nothing
    req = 1'b1; req_kind = 3'd6; tick();
    check_idle("R2");
    req_kind = 3'd7; tick();
    check_idle("R2");
    req_kind = 3'd0; ce = 1'b0;
    @(posedge clk); @(negedge clk);
    check_idle("R2");
    req = 1'b0; tick();
    check_idle("R2");

    // directed: each kind with no waits, then with waits
    for (int kd = 0; kd < 6; kd++) run_cycle(3'(kd), 0, 0, 1'b0);
    for (int kd = 0; kd < 6; kd++) run_cycle(3'(kd), 3, 1, 1'b0);
    run_cycle(3'd5, 1, 2, 1'b1);
    run_cycle(3'd3, 2, 0, 1'b1);

    // random mix
    for (int i = 0; i < 80; i++)
      run_cycle(3'($urandom_range(0, 5)), $urandom_range(0, 3), 2, 1'($urandom));

    check_idle("R1");
    finish_run();
  end

endmodule